// File: doc/BRIEF.md
# Boost Converter Real-Time State Solver

This block advances a model of a boost power stage by one explicit forward Euler step each time it is strobed. It is meant for hardware-in-the-loop rigs, where a controller under test drives the gate and reads back modelled quantities. The model has two state variables, the inductor current and the output capacitor voltage. Both are updated together from the previous step's values, using one of three conduction cases. The switch may be on. The switch may be off with the diode conducting. The switch may be off with the inductor fully discharged.

All state and sample values are signed fixed-point with a parameterised number of fraction bits. This lets a designer see how the fraction width limits the smallest increment that still moves a large state value. The coefficients step/L and step/C are computed outside the block and fed in as small unsigned fractions. For a 50 ns step they are of the order of 1e-4. The gate signal, the input voltage sample and the load current sample come from the surrounding rig.

Top module: `boost_state_solver`

## Requirements
- R1: In one step both states are updated at once, and each update uses only the current and voltage held before that step.
- R2: Number format: current, voltage, input voltage and load current are signed two's complement values with INT_W integer bits and FRAC_W fraction bits. The coefficients are unsigned values with COEF_W bits, all of them fraction bits. With gate=1 the next current is i + kl*vg, the next voltage is v - kc*ir, and the mode flag reads 0.
- R3: With gate=0 and a current above zero, the diode conducts. The next current is i + kl*(vg - v) and the next voltage is v + kc*(i - ir).
- R4: With gate=0 and a current of zero or below, the next current is 0, the next voltage is v - kc*ir, and the mode flag reads 1.
- R5: With gate=0, when the diode-case current result is zero or negative, the stored current is 0 and the mode flag reads 1 for that step.
- R6: The state and the mode flag change only on a clock edge where step_en is high. Input changes while step_en is low have no effect.
- R7: While rst_n is low, each clock edge loads il_init and vc_init into the state. The valid and mode flags clear at once when rst_n falls.
- R8: Each coefficient product is formed at full width, then cut to the state format by truncating its magnitude toward zero. An increment smaller than one LSB therefore leaves the state unchanged.
- R9: Each addition saturates to the largest or the smallest representable state value instead of wrapping.
- R10: valid_out is high for exactly the one clock cycle that follows each update edge, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, released synchronously |
| step_en | input | 1 | Advance the model by one step on this edge |
| gate | input | 1 | Switch command, 1 = switch closed |
| vg_in | input | INT_W+FRAC_W | Input voltage sample |
| ir_in | input | INT_W+FRAC_W | Load current sample |
| kl_in | input | COEF_W | step/L coefficient |
| kc_in | input | COEF_W | step/C coefficient |
| il_init | input | INT_W+FRAC_W | Current loaded during reset |
| vc_init | input | INT_W+FRAC_W | Voltage loaded during reset |
| il_out | output | INT_W+FRAC_W | Inductor current state |
| vc_out | output | INT_W+FRAC_W | Capacitor voltage state |
| dcm_out | output | 1 | Discontinuous-conduction flag of the last step |
| valid_out | output | 1 | One-cycle pulse after each update |

## Verification
The stepping function is exercised with five input patterns. Switch-on charging at 230 V tests the closed-switch case. Switch-off discharge against 400 V runs from a positive current down to the clamp, which separates the diode case from the clamp. A further switch-off step from zero current isolates the fully discharged case. A long run of tiny load-driven decrements on a 400 V state is applied to a wide and a narrow fraction width at once. The wide width must follow a real-valued model within the truncation bound, and the narrow width must stall at exactly 400 V, which shows truncation toward zero at work. A near-full-scale voltage with a large diode current must clip at the maximum code rather than wrap.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [1:0] {
    CASE_ON    = 2'd0,
    CASE_DIODE = 2'd1,
    CASE_EMPTY = 2'd2
  } bss_case_e;
endpackage

// File: rtl/bss_scale.sv
// Multiply a signed difference by an unsigned fractional coefficient and
// cut the product back to the state format, truncating toward zero.
module bss_scale #(
  parameter int SW = 32,
  parameter int CW = 24
) (
  input  logic signed [SW:0]   diff,
  input  logic        [CW-1:0] coef,
  output logic signed [SW:0]   incr
);
  localparam int PW = SW + CW + 2;

  logic signed [PW-1:0] d_ext;
  logic signed [PW-1:0] c_ext;
  logic signed [PW-1:0] prod;
  logic        [PW-1:0] mag;
  logic        [SW:0]   mag_q;
  logic                 neg;

  always_comb begin
    d_ext = PW'(diff);
    c_ext = PW'($signed({1'b0, coef}));
    prod  = d_ext * c_ext;
    neg   = prod[PW-1];
    mag   = neg ? PW'(-prod) : PW'(prod);
    mag_q = (SW+1)'(mag >> CW);
    incr  = neg ? -$signed(mag_q) : $signed(mag_q);
  end

  logic [SW:0] abs_in;
  logic [SW:0] abs_out;
  always_comb begin
    abs_in  = diff[SW] ? (SW+1)'(-diff) : (SW+1)'(diff);
    abs_out = incr[SW] ? (SW+1)'(-incr) : (SW+1)'(incr);
    AST_SCALE_SHRINK: assert (abs_out <= abs_in) else $error("scaled magnitude grew"); // R8
    AST_SCALE_SIGN: assert (incr == '0 || incr[SW] == diff[SW]) else $error("scaled sign flipped"); // R8
  end
endmodule

// File: rtl/bss_sat_add.sv
// Add a signed increment to a state value with clipping at both ends.
module bss_sat_add #(
  parameter int SW = 32
) (
  input  logic signed [SW-1:0] base,
  input  logic signed [SW:0]   incr,
  output logic signed [SW-1:0] sum
);
  localparam logic signed [SW+1:0] MAXW = {3'b000, {(SW-1){1'b1}}};
  localparam logic signed [SW+1:0] MINW = {3'b111, {(SW-1){1'b0}}};

  logic signed [SW+1:0] wide;

  always_comb begin
    wide = {{2{base[SW-1]}}, base} + {incr[SW], incr};
    if (wide > MAXW)      sum = MAXW[SW-1:0];
    else if (wide < MINW) sum = MINW[SW-1:0];
    else                  sum = wide[SW-1:0];
  end
endmodule

// File: rtl/bss_case_sel.sv
// Pick the conduction case and form the two Euler differences.
module bss_case_sel
  import bss_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic                 gate,
  input  logic signed [SW-1:0] il,
  input  logic signed [SW-1:0] vc,
  input  logic signed [SW-1:0] vg,
  input  logic signed [SW-1:0] ir,
  output bss_case_e            sel,
  output logic signed [SW:0]   dl,
  output logic signed [SW:0]   dv
);
  logic signed [SW:0] il_x;
  logic signed [SW:0] vc_x;
  logic signed [SW:0] vg_x;
  logic signed [SW:0] ir_x;

  always_comb begin
    il_x = {il[SW-1], il};
    vc_x = {vc[SW-1], vc};
    vg_x = {vg[SW-1], vg};
    ir_x = {ir[SW-1], ir};

    if (gate)                         sel = CASE_ON;
    else if (!il[SW-1] && il != '0)   sel = CASE_DIODE;
    else                              sel = CASE_EMPTY;

    case (sel)
      CASE_ON: begin
        dl = vg_x;
        dv = -ir_x;
      end
      CASE_DIODE: begin
        dl = vg_x - vc_x;
        dv = il_x - ir_x;
      end
      default: begin
        dl = '0;
        dv = -ir_x;
      end
    endcase
  end
endmodule

// File: rtl/boost_state_solver.sv
module boost_state_solver
  import bss_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 20,
  parameter int COEF_W = 24
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              step_en,
  input  logic                              gate,
  input  logic signed [INT_W+FRAC_W-1:0]    vg_in,
  input  logic signed [INT_W+FRAC_W-1:0]    ir_in,
  input  logic        [COEF_W-1:0]          kl_in,
  input  logic        [COEF_W-1:0]          kc_in,
  input  logic signed [INT_W+FRAC_W-1:0]    il_init,
  input  logic signed [INT_W+FRAC_W-1:0]    vc_init,
  output logic signed [INT_W+FRAC_W-1:0]    il_out,
  output logic signed [INT_W+FRAC_W-1:0]    vc_out,
  output logic                              dcm_out,
  output logic                              valid_out
);
  localparam int SW    = INT_W + FRAC_W;
  localparam int LANES = 2;

  logic signed [SW-1:0] il_q, vc_q;
  logic signed [SW-1:0] il_nx, vc_nx;
  logic                 dcm_q, dcm_nx;
  logic                 valid_q;
  bss_case_e            sel;
  logic signed [SW:0]   dl, dv;

  logic signed [SW:0]     diff_a [LANES];
  logic        [COEF_W-1:0] coef_a [LANES];
  logic signed [SW:0]     incr_a [LANES];
  logic signed [SW-1:0]   base_a [LANES];
  logic signed [SW-1:0]   sum_a  [LANES];

  bss_case_sel #(.SW(SW)) u_sel (
    .gate (gate),
    .il   (il_q),
    .vc   (vc_q),
    .vg   (vg_in),
    .ir   (ir_in),
    .sel  (sel),
    .dl   (dl),
    .dv   (dv)
  );

  // lane 0 = inductor current, lane 1 = capacitor voltage
  assign diff_a[0] = dl;
  assign diff_a[1] = dv;
  assign coef_a[0] = kl_in;
  assign coef_a[1] = kc_in;
  assign base_a[0] = il_q;
  assign base_a[1] = vc_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bss_scale #(.SW(SW), .CW(COEF_W)) u_scale (
      .diff (diff_a[g]),
      .coef (coef_a[g]),
      .incr (incr_a[g])
    );
    bss_sat_add #(.SW(SW)) u_add (
      .base (base_a[g]),
      .incr (incr_a[g]),
      .sum  (sum_a[g])
    );
  end

  // next-state selection
  always_comb begin
    il_nx  = sum_a[0];
    vc_nx  = sum_a[1];
    dcm_nx = 1'b0;
    case (sel)
      CASE_ON: ;
      CASE_DIODE: begin
        if (sum_a[0][SW-1] || sum_a[0] == '0) begin
          il_nx  = '0;
          dcm_nx = 1'b1;
        end
      end
      default: begin
        il_nx  = '0;
        dcm_nx = 1'b1;
      end
    endcase
  end

  // datapath state: synchronous load of initial values during reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      il_q <= il_init;
      vc_q <= vc_init;
    end else if (step_en) begin
      il_q <= il_nx;
      vc_q <= vc_nx;
    end
  end

  // control flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcm_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= step_en;
      if (step_en) dcm_q <= dcm_nx;
    end
  end

  assign il_out    = il_q;
  assign vc_out    = vc_q;
  assign dcm_out   = dcm_q;
  assign valid_out = valid_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(il_q) && $stable(vc_q) && $stable(dcm_q)); // R6
  AST_OFF_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !gate |=> !il_q[SW-1]); // R5
  AST_DCM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dcm_q |-> il_q == '0); // R4
  AST_ON_CLEARS_DCM: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && gate |=> !dcm_q); // R2
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> valid_q); // R10
  AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> !valid_q); // R10
endmodule

// File: tb/boost_state_solver_test.sv
`timescale 1ns/1ps
module boost_state_solver_test;
  localparam int  IW  = 12;
  localparam int  FW  = 20;
  localparam int  FWN = 10;
  localparam int  CW  = 24;
  localparam int  SW  = IW + FW;
  localparam int  SWN = IW + FWN;

  logic clk = 1'b0;
  logic rst_n, step_en, gate;
  logic signed [SW-1:0]  vg_w, ir_w, ili_w, vci_w, il_w, vc_w;
  logic signed [SWN-1:0] vg_n, ir_n, ili_n, vci_n, il_n, vc_n;
  logic [CW-1:0] kl_v, kc_v;
  logic dcm_w, valid_w, dcm_n, valid_n;

  int checks = 0;
  int errs   = 0;
  longint kl, kc;
  longint m_il, m_vc, n_il, n_vc;
  bit     m_dcm, n_dcm;

  always #4 clk = ~clk;

  boost_state_solver #(.INT_W(IW), .FRAC_W(FW), .COEF_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .gate(gate),
    .vg_in(vg_w), .ir_in(ir_w), .kl_in(kl_v), .kc_in(kc_v),
    .il_init(ili_w), .vc_init(vci_w),
    .il_out(il_w), .vc_out(vc_w), .dcm_out(dcm_w), .valid_out(valid_w));

  boost_state_solver #(.INT_W(IW), .FRAC_W(FWN), .COEF_W(CW)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .gate(gate),
    .vg_in(vg_n), .ir_in(ir_n), .kl_in(kl_v), .kc_in(kc_v),
    .il_init(ili_n), .vc_init(vci_n),
    .il_out(il_n), .vc_out(vc_n), .dcm_out(dcm_n), .valid_out(valid_n));

  function automatic longint fx(real v, int frac);
    return longint'(v * (2.0 ** frac));
  endfunction

  function automatic longint scl(longint d, longint k);
    longint p = d * k;
    if (p < 0) return -((-p) >>> CW);
    return p >>> CW;
  endfunction

  function automatic longint sat(longint v, int sw);
    longint mx = (longint'(1) << (sw - 1)) - 1;
    longint mn = -(longint'(1) << (sw - 1));
    if (v > mx) return mx;
    if (v < mn) return mn;
    return v;
  endfunction

  task automatic mstep(inout longint il, inout longint vc, output bit dcm,
                       input bit g, input longint vg, input longint ir, input int sw);
    longint nil, nvc;
    dcm = 1'b0;
    if (g) begin
      nil = sat(il + scl(vg, kl), sw);
      nvc = sat(vc - scl(ir, kc), sw);
    end else if (il > 0) begin
      nil = sat(il + scl(vg - vc, kl), sw);
      nvc = sat(vc + scl(il - ir, kc), sw);
      if (nil <= 0) begin nil = 0; dcm = 1'b1; end
    end else begin
      nil = 0;
      nvc = sat(vc - scl(ir, kc), sw);
      dcm = 1'b1;
    end
    il = nil;
    vc = nvc;
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk(longint'($signed(il_w)) == m_il, req, "current", longint'($signed(il_w)), m_il);
    chk(longint'($signed(vc_w)) == m_vc, req, "voltage", longint'($signed(vc_w)), m_vc);
    chk(dcm_w == m_dcm, req, "mode flag", longint'(dcm_w), longint'(m_dcm));
  endtask

  task automatic set_in(real vg, real ir);
    vg_w = SW'(fx(vg, FW));   ir_w = SW'(fx(ir, FW));
    vg_n = SWN'(fx(vg, FWN)); ir_n = SWN'(fx(ir, FWN));
  endtask

  task automatic apply_reset(real il0, real vc0);
    @(negedge clk);
    rst_n = 1'b0; step_en = 1'b0;
    ili_w = SW'(fx(il0, FW));   vci_w = SW'(fx(vc0, FW));
    ili_n = SWN'(fx(il0, FWN)); vci_n = SWN'(fx(vc0, FWN));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_il = longint'($signed(ili_w)); m_vc = longint'($signed(vci_w)); m_dcm = 1'b0;
    n_il = longint'($signed(ili_n)); n_vc = longint'($signed(vci_n)); n_dcm = 1'b0;
  endtask

  // called at a negedge; returns at the negedge after the update edge
  task automatic do_step();
    step_en = 1'b1;
    @(posedge clk);
    mstep(m_il, m_vc, m_dcm, gate, longint'($signed(vg_w)), longint'($signed(ir_w)), SW);
    mstep(n_il, n_vc, n_dcm, gate, longint'($signed(vg_n)), longint'($signed(ir_n)), SWN);
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic t_reset();
    apply_reset(1.5, 400.0);
    chk(il_w == ili_w, "R7", "reset current", longint'($signed(il_w)), longint'($signed(ili_w)));
    chk(vc_w == vci_w, "R7", "reset voltage", longint'($signed(vc_w)), longint'($signed(vci_w)));
    chk(!valid_w, "R7", "reset valid", longint'(valid_w), 0);
    chk(!dcm_w, "R7", "reset mode flag", longint'(dcm_w), 0);
  endtask

  task automatic t_switch_on();
    apply_reset(0.0, 400.0);
    gate = 1'b1; set_in(230.0, 0.1);
    for (int i = 0; i < 5; i++) begin
      do_step();
      chk_state("R2 R1");
    end
    chk(valid_w == 1'b1, "R10", "valid after step", longint'(valid_w), 1);
    @(negedge clk);
    chk(valid_w == 1'b0, "R10", "valid one cycle only", longint'(valid_w), 0);
  endtask

  task automatic t_diode_clamp();
    bit seen = 1'b0;
    gate = 1'b0; set_in(230.0, 0.1);
    do_step();
    chk_state("R3 R1");
    chk(m_il > 0, "R3", "diode step keeps current positive", m_il, 1);
    for (int i = 0; i < 30 && !seen; i++) begin
      do_step();
      chk_state("R5");
      if (m_dcm) seen = 1'b1;
    end
    chk(seen && il_w == '0 && dcm_w, "R5", "clamp reached with flag",
        longint'($signed(il_w)), 0);
  endtask

  task automatic t_empty();
    longint v0 = longint'($signed(vc_w));
    gate = 1'b0; set_in(230.0, 0.5);
    do_step();
    chk_state("R4");
    chk(longint'($signed(vc_w)) == v0 - scl(longint'($signed(ir_w)), kc), "R4",
        "voltage falls by load term", longint'($signed(vc_w)), v0 - scl(longint'($signed(ir_w)), kc));
    // async clear of flags
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!dcm_w, "R7", "mode flag clears asynchronously", longint'(dcm_w), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_hold();
    apply_reset(0.0, 400.0);
    gate = 1'b1; set_in(100.0, 0.2);
    do_step();
    chk_state("R6");
    gate = 1'b0; set_in(-50.0, 3.0);
    repeat (5) @(negedge clk);
    chk_state("R6");
    chk(!valid_w, "R6", "no valid while idle", longint'(valid_w), 0);
  endtask

  task automatic t_stall();
    real r_vc = 400.0;
    real kc_r = real'(kc) / (2.0 ** CW);
    real diff_r;
    apply_reset(0.0, 400.0);
    gate = 1'b1; set_in(0.0, 0.1);
    for (int i = 0; i < 200; i++) begin
      do_step();
      r_vc = r_vc - kc_r * 0.1;
    end
    chk(longint'($signed(vc_n)) == fx(400.0, FWN), "R8", "narrow width stalls",
        longint'($signed(vc_n)), fx(400.0, FWN));
    chk(longint'($signed(vc_n)) == n_vc, "R8", "narrow matches model", longint'($signed(vc_n)), n_vc);
    chk_state("R8");
    chk(longint'($signed(vc_w)) < fx(400.0, FW) - 1000, "R8", "wide width decreases",
        longint'($signed(vc_w)), fx(400.0, FW) - 1000);
    diff_r = real'(longint'($signed(vc_w))) / (2.0 ** FW) - r_vc;
    if (diff_r < 0.0) diff_r = -diff_r;
    chk(diff_r <= 200.0 / (2.0 ** FW) + 1e-6, "R8", "wide near real model",
        longint'(diff_r * 1e9), longint'((200.0 / (2.0 ** FW)) * 1e9));
  endtask

  task automatic t_sat();
    apply_reset(2000.0, 2047.9);
    gate = 1'b0; set_in(0.0, 0.0);
    do_step();
    chk(longint'($signed(vc_w)) == (longint'(1) << (SW - 1)) - 1, "R9", "voltage clips at max",
        longint'($signed(vc_w)), (longint'(1) << (SW - 1)) - 1);
    chk_state("R9");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; step_en = 1'b0; gate = 1'b0;
    kl = fx(50e-9 / 416.5e-6, CW);
    kc = fx(50e-9 / 540.5e-6, CW);
    kl_v = CW'(kl); kc_v = CW'(kc);
    set_in(0.0, 0.0);
    ili_w = '0; vci_w = '0; ili_n = '0; vci_n = '0;
    t_reset();
    t_switch_on();
    t_diode_clamp();
    t_empty();
    t_hold();
    t_stall();
    t_sat();
    finish_run();
  end
endmodule